// File: doc/BRIEF.md
# Flash Region Lock Protection Unit

This unit holds one small lock register for every protectable region of a flash array and decides, for each program, erase or read request, whether the request may go ahead. Each register carries three control bits. One keeps the region from being programmed or erased. One hides the region's data from array reads. One freezes the register itself until the next reset. The registers sit on a plain address/data bus. Software reaches them with a single read or write at the register address, and no command sequence is needed.

Two active-low pins override the registers in hardware. One pin guards the highest-numbered (top) region. The other pin guards every other region. The access check is purely combinational. For the region named on the request port it returns a permit flag, an error flag for the status logic and an 8-bit mask for the read data. The flash array, command decoding and the status register itself sit outside this unit.

Top module: `region_guard`

## Requirements
- R1: On a cycle with `rst` high, every region's register takes the value 0x01: write lock 1, lock down 0, read lock 0. This value is visible from the next cycle.
- R2: A register read (`bus_rd` high at a register address) returns `{5'b0, read_lock, lock_down, write_lock}` in the same cycle. Bit 0 is write lock, bit 1 is lock down and bit 2 is read lock. `bus_rdata` is 0 when no register read is in progress.
- R3: A register write (`bus_wr` high at a register address) to a region whose lock down bit is 0 loads `bus_wdata[2:0]` into that region's register at the clock edge. `bus_wdata[7:3]` are ignored.
- R4: A register address has bit 22 equal to 0, the region index in bits 19:16 and every other address bit 0. Any other address neither changes a register nor returns nonzero read data.
- R5: While a region's lock down bit is 1, every write to its register is dropped whole, including an attempt to clear lock down. Only `rst` returns the register to its reset value.
- R6: A program or erase request (`op_prog` or `op_erase` high) to a region whose write lock bit is 1 gives `op_permit`=0 and `op_err`=1.
- R7: While `top_lock_n` is 0, program and erase requests to the top region (index NUM_REGIONS-1) are denied with `op_err`=1, whatever its register holds. The pin has no effect on the other regions.
- R8: While `main_wp_n` is 0, program and erase requests to regions 0 to NUM_REGIONS-2 are denied with `op_err`=1. The pin has no effect on the top region.
- R9: A program or erase request is permitted (`op_permit`=1, `op_err`=0) exactly when the region's write lock bit is 0 and no pin protects the region.
- R10: `rd_mask` is 0x00 when the requested region's read lock bit is 1, and 0xFF otherwise. A read-only request (`op_read` high, `op_prog` and `op_erase` low) gives `op_permit`=1 and `op_err`=0. With no request, both flags are 0.
- R11: A register read returns the register's current contents even while the region is read-locked or locked down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| top_lock_n | input | 1 | Active-low write guard for the top region |
| main_wp_n | input | 1 | Active-low write guard for all other regions |
| op_region | input | IDX_W | Region index of the array request |
| op_prog | input | 1 | Program request |
| op_erase | input | 1 | Erase request |
| op_read | input | 1 | Array read request |
| op_permit | output | 1 | Request may proceed |
| op_err | output | 1 | Program or erase denied, toward the status register |
| rd_mask | output | 8 | AND mask for array read data |

## Verification
The bench sweeps every region against all four pin combinations and every request kind, after several different register patterns have been loaded. A design that routed a pin to the wrong region, or let one pin leak onto the other's regions, fails that sweep. The bench attempts writes to frozen registers, including writes that clear lock down, and reads the registers back over the bus. A design that applied part of such a write, or let reset-only state be cleared by software, shows the wrong contents there. It also writes through addresses with bit 22 set or with a stray low bit, and writes junk into bits 7:3. A loose address decode or an unmasked data field shows up as a changed register or nonzero read-back.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

    // Field positions inside one lock register byte
    localparam int WL_POS = 0;
    localparam int LD_POS = 1;
    localparam int RL_POS = 2;

    typedef struct packed {
        logic rd_lock;    // bit 2
        logic lock_down;  // bit 1
        logic wr_lock;    // bit 0
    } lock_bits_t;

    localparam lock_bits_t LOCK_RESET = '{rd_lock: 1'b0, lock_down: 1'b0, wr_lock: 1'b1};
    localparam lock_bits_t LOCK_ABSENT = '{rd_lock: 1'b1, lock_down: 1'b1, wr_lock: 1'b1};

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_MODIFY = 2'd1,
        OP_READ   = 2'd2
    } op_kind_t;

    function automatic logic [7:0] pack_reg(lock_bits_t b);
        return {5'b0, b};
    endfunction

    function automatic lock_bits_t unpack_reg(logic [2:0] d);
        lock_bits_t b;
        b.wr_lock   = d[WL_POS];
        b.lock_down = d[LD_POS];
        b.rd_lock   = d[RL_POS];
        return b;
    endfunction

    // Program and erase dominate a simultaneous read
    function automatic op_kind_t classify(logic prog, logic erase, logic rd);
        if (prog || erase) return OP_MODIFY;
        if (rd)            return OP_READ;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/region_lock_bank.sv
module region_lock_bank
    import region_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int IDX_W       = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_req,
    input  logic [IDX_W-1:0]              wr_idx,
    input  lock_bits_t                    wr_bits,
    output lock_bits_t [NUM_REGIONS-1:0]  locks
);

    lock_bits_t q [NUM_REGIONS];

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
        logic hit;
        assign hit = wr_req && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= LOCK_RESET;
            else if (hit && !q[i].lock_down)
                q[i] <= wr_bits;
        end

        assign locks[i] = q[i];

        // R1: reset value
        a_r1_reset_value: assert property (@(posedge clk)
            rst |=> (q[i] == LOCK_RESET));

        // R5: a frozen register keeps its value until reset
        a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
            q[i].lock_down |=> $stable(q[i]));

        // R3: an accepted write lands on the next edge
        a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
            (hit && !q[i].lock_down) |=> (q[i] == $past(wr_bits)));
    end

endmodule

// File: rtl/region_pin_guard.sv
module region_pin_guard #(
    parameter int NUM_REGIONS = 16
) (
    input  logic                   top_lock_n,
    input  logic                   main_wp_n,
    output logic [NUM_REGIONS-1:0] pin_prot
);

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_pin
        if (i == NUM_REGIONS - 1) begin : g_top
            assign pin_prot[i] = !top_lock_n;
        end else begin : g_main
            assign pin_prot[i] = !main_wp_n;
        end
    end

endmodule

// File: rtl/region_access_gate.sv
module region_access_gate
    import region_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int IDX_W       = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  lock_bits_t [NUM_REGIONS-1:0]  locks,
    input  logic [NUM_REGIONS-1:0]        pin_prot,
    input  logic [IDX_W-1:0]              op_region,
    input  logic                          op_prog,
    input  logic                          op_erase,
    input  logic                          op_read,
    output logic                          op_permit,
    output logic                          op_err,
    output logic [7:0]                    rd_mask
);

    logic       idx_ok;
    lock_bits_t cur;
    logic       pin_hit;
    logic       mod_ok;
    op_kind_t   kind;

    if (NUM_REGIONS == (1 << IDX_W)) begin : g_full
        assign idx_ok = 1'b1;
    end else begin : g_part
        assign idx_ok = (int'(op_region) < NUM_REGIONS);
    end

    assign cur     = idx_ok ? locks[op_region] : LOCK_ABSENT;
    assign pin_hit = idx_ok ? pin_prot[op_region] : 1'b1;
    assign mod_ok  = !cur.wr_lock && !pin_hit;
    assign kind    = classify(op_prog, op_erase, op_read);

    always_comb begin
        op_permit = 1'b0;
        op_err    = 1'b0;
        unique case (kind)
            OP_MODIFY: begin
                op_permit = mod_ok;
                op_err    = !mod_ok;
            end
            OP_READ:   op_permit = 1'b1;
            default:   ;
        endcase
    end

    assign rd_mask = cur.rd_lock ? 8'h00 : 8'hFF;

    // R6: write lock denies program/erase
    a_r6_wl_denies: assert property (@(posedge clk) disable iff (rst)
        ((op_prog || op_erase) && cur.wr_lock) |-> (!op_permit && op_err));

    // R10: error flag only ever follows a modify request
    a_r10_err_needs_modify: assert property (@(posedge clk) disable iff (rst)
        op_err |-> (op_prog || op_erase));

    // R10: an open mask implies an unlocked region
    a_r10_mask_open: assert property (@(posedge clk) disable iff (rst)
        (rd_mask != 8'h00) |-> !cur.rd_lock);

    // R9: permit and error never together
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(op_permit && op_err));

endmodule

// File: rtl/region_guard.sv
module region_guard
    import region_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 23,
    parameter int IDX_LSB     = 16,
    parameter int SPACE_BIT   = 22,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              top_lock_n,
    input  logic              main_wp_n,
    input  logic [IDX_W-1:0]  op_region,
    input  logic              op_prog,
    input  logic              op_erase,
    input  logic              op_read,
    output logic              op_permit,
    output logic              op_err,
    output logic [7:0]        rd_mask
);

    localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'((1 << IDX_W) - 1) << IDX_LSB;

    lock_bits_t [NUM_REGIONS-1:0] locks;
    logic [NUM_REGIONS-1:0]       pin_prot;
    logic [IDX_W-1:0]             reg_idx;
    logic                         reg_hit;
    logic                         idx_ok;
    logic [4:0]                   unused_wdata_hi;

    // Register space: space bit clear and all non-index bits zero
    assign reg_idx = bus_addr[IDX_LSB +: IDX_W];
    assign reg_hit = ((bus_addr & ~IDX_MASK) == '0);
    assign unused_wdata_hi = bus_wdata[7:3];

    if (NUM_REGIONS == (1 << IDX_W)) begin : g_full
        assign idx_ok = 1'b1;
    end else begin : g_part
        assign idx_ok = (int'(reg_idx) < NUM_REGIONS);
    end

    assign bus_rdata = (bus_rd && reg_hit && idx_ok) ? pack_reg(locks[reg_idx]) : 8'h00;

    region_lock_bank #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (bus_wr && reg_hit),
        .wr_idx  (reg_idx),
        .wr_bits (unpack_reg(bus_wdata[2:0])),
        .locks   (locks)
    );

    region_pin_guard #(.NUM_REGIONS(NUM_REGIONS)) u_pins (
        .top_lock_n (top_lock_n),
        .main_wp_n  (main_wp_n),
        .pin_prot   (pin_prot)
    );

    region_access_gate #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .locks     (locks),
        .pin_prot  (pin_prot),
        .op_region (op_region),
        .op_prog   (op_prog),
        .op_erase  (op_erase),
        .op_read   (op_read),
        .op_permit (op_permit),
        .op_err    (op_err),
        .rd_mask   (rd_mask)
    );

    // R7: top pin guards the top region
    a_r7_top_pin: assert property (@(posedge clk) disable iff (rst)
        (!top_lock_n && (op_prog || op_erase) && (int'(op_region) == NUM_REGIONS - 1))
            |-> (!op_permit && op_err));

    // R8: main pin guards every other region
    a_r8_main_pin: assert property (@(posedge clk) disable iff (rst)
        (!main_wp_n && (op_prog || op_erase) && (int'(op_region) < NUM_REGIONS - 1))
            |-> (!op_permit && op_err));

    // R4: outside register space reads return zero
    a_r4_outside_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[SPACE_BIT]) |-> (bus_rdata == 8'h00));

    // R2: upper read-back bits are always zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[7:3] == 5'b0);

endmodule

// File: tb/region_guard_bench.sv
module region_guard_bench;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [22:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        top_lock_n = 1'b1, main_wp_n = 1'b1;
    logic [3:0]  op_region = '0;
    logic        op_prog = 1'b0, op_erase = 1'b0, op_read = 1'b0;
    logic        op_permit, op_err;
    logic [7:0]  rd_mask;

    int total = 0;
    int bad   = 0;
    logic [2:0] m [N];   // model: {read lock, lock down, write lock}

    always #5 clk = ~clk;

    region_guard u_region_guard (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .top_lock_n(top_lock_n),
        .main_wp_n(main_wp_n), .op_region(op_region), .op_prog(op_prog),
        .op_erase(op_erase), .op_read(op_read), .op_permit(op_permit),
        .op_err(op_err), .rd_mask(rd_mask)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [22:0] mk_addr(int idx, bit space, bit stray);
        return {space, 2'b00, 4'(idx), 15'b0, stray};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < N; i++) m[i] = 3'b001;
    endtask

    task automatic do_write(int idx, logic [7:0] d, bit space, bit stray);
        @(negedge clk);
        bus_addr = mk_addr(idx, space, stray); bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        if (!space && !stray && !m[idx][1]) m[idx] = d[2:0];
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_all(string req);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            bus_addr = mk_addr(i, 1'b0, 1'b0); bus_rd = 1'b1;
            #1 check(req, $sformatf("readback r%0d", i), bus_rdata, {5'b0, m[i]});
            bus_rd = 1'b0;
            #1 check("R2", "idle rdata", bus_rdata, 0);
        end
    endtask

    task automatic sweep(string req);
        for (int r = 0; r < N; r++)
            for (int p = 0; p < 4; p++)
                for (int k = 0; k < 4; k++) begin
                    bit tl, wp, pin, mod;
                    logic ep, ee;
                    tl = p[0]; wp = p[1];
                    top_lock_n = tl; main_wp_n = wp; op_region = 4'(r);
                    op_prog = (k == 0); op_erase = (k == 1); op_read = (k == 2);
                    pin = (r == N - 1) ? !tl : !wp;
                    mod = (k < 2);
                    ep = mod ? (!m[r][0] && !pin) : (k == 2);
                    ee = mod ? !(!m[r][0] && !pin) : 1'b0;
                    #1;
                    check(req, $sformatf("permit r%0d p%0d k%0d", r, p, k), op_permit, ep);
                    check(req, $sformatf("err r%0d p%0d k%0d", r, p, k), op_err, ee);
                    check("R10", $sformatf("mask r%0d", r), rd_mask, m[r][2] ? 8'h00 : 8'hFF);
                end
        op_prog = 0; op_erase = 0; op_read = 0; top_lock_n = 1; main_wp_n = 1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 defaults, R2 field layout
        read_all("R1");
        sweep("R9");

        // R3: plain writes with junk in bits 7:3, lock down kept clear
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < N; i++)
                do_write(i, {5'b10110, 3'(((v + i) % 8) & 5)}, 1'b0, 1'b0);
            read_all("R3");
            sweep(v[0] ? "R6" : "R9");
        end
        // R7/R8 with all regions writable
        for (int i = 0; i < N; i++) do_write(i, 8'h00, 1'b0, 1'b0);
        sweep("R7");
        sweep("R8");

        // R4: writes outside register space have no effect
        do_write(3, 8'h05, 1'b1, 1'b0);
        do_write(4, 8'h05, 1'b0, 1'b1);
        read_all("R4");
        @(negedge clk);
        bus_addr = mk_addr(3, 1'b1, 1'b0); bus_rd = 1'b1;
        #1 check("R4", "space bit read", bus_rdata, 0);
        bus_addr = mk_addr(3, 1'b0, 1'b1);
        #1 check("R4", "stray bit read", bus_rdata, 0);
        bus_rd = 1'b0;

        // R5: lock down on even regions, then try to clear everything
        for (int i = 0; i < N; i++)
            if (i % 2 == 0) do_write(i, 8'(((i / 2) % 8) | 2), 1'b0, 1'b0);
        for (int i = 0; i < N; i++) do_write(i, 8'h00, 1'b0, 1'b0);
        read_all("R5");
        for (int i = 0; i < N; i++) do_write(i, 8'h07, 1'b0, 1'b0);
        read_all("R11");
        sweep("R10");

        // R1: reset releases lock down
        do_reset();
        read_all("R1");
        do_write(0, 8'h00, 1'b0, 1'b0);
        read_all("R5");
        sweep("R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule